// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps transitions on an asynchronous external pin against a 16-bit free-running counter. The counter is driven through a fixed divide-by-four prescaler, so it advances once every four system clocks. The pin passes through a two-flop synchronizer and an edge detector. When the chosen polarity is seen, the counter value is written into a 16-bit capture register. Software reads that register one byte at a time through a small read port.

The usual use is measuring time between transitions. Two captures on edges of the same polarity give a period. Flipping the edge-select bit between two captures gives a pulse width. The stored value is intentionally one count past the counter value that was current when the pin changed; this offset is the cost of synchronization.

A capture flag reports new data. Reading the high byte freezes the register until the low byte is read, so a byte pair always comes from one capture.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset is released the counter holds 0xFFFC. It increments by exactly one on every fourth rising clock edge, with the first increment on the fourth edge after release.
- R2: A capture stores one plus the counter value seen at the clock edge that first samples the pin change. That counter value is taken before the edge's own update.
- R3: When edge_rise_i is 1, only low-to-high pin transitions capture. When it is 0, only high-to-low transitions capture. A transition of the other polarity leaves the flag and the register unchanged.
- R4: rd_addr_i = 0 selects the high byte (bits 15:8) and rd_addr_i = 1 selects the low byte (bits 7:0). rd_data_o shows the selected byte combinationally in the same cycle.
- R5: Reset does not modify the capture register. After reset its bytes read back the value stored before reset.
- R6: The capture flag is 0 after reset. If the pin changes between clock edges k-1 and k, the flag is still 0 after edge k+1 and is 1 after edge k+2.
- R7: A read of the low byte clears the flag. If a capture lands in the same cycle as that read, the flag stays set, and the read returns the byte from before the capture.
- R8: A read of the high byte blocks every capture until the next low-byte read. An edge arriving while blocked is dropped and changes neither the register nor the flag.
- R9: The counter wraps from 0xFFFF to 0x0000, and a capture taken across the wrap stores the wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| edge_rise_i | input | 1 | Active edge select: 1 rising, 0 falling |
| rd_en_i | input | 1 | Read strobe, enables read side effects |
| rd_addr_i | input | 1 | Byte select: 0 high byte, 1 low byte |
| rd_data_o | output | 8 | Selected capture register byte |
| cap_flag_o | output | 1 | Capture flag |

## Verification
The counter and prescaler are never visible at the ports. A wrong phase or start value therefore shows up only as a capture value that is off by one or more counts. The bench places pin transitions at chosen edge counts so that every capture exposes the counter state within three clocks of the transition. A synchronizer pipeline of the wrong depth moves the flag's rising edge by a cycle; the bench catches this by sampling the flag on both sides of the expected edge. A stuck lock or flag appears at the next read as a stale byte or a flag level that persists.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    // Byte select encoding on the read port
    typedef enum logic {
        BYTE_HI = 1'b0,
        BYTE_LO = 1'b1
    } byte_sel_e;

endpackage

// File: rtl/tcu_counter.sv
module tcu_counter #(
    parameter int              CNT_W     = 16,
    parameter int              PRESCALE  = 4,
    parameter logic [CNT_W-1:0] CNT_RESET = 16'hFFFC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ps == PS_LAST) begin
            st_d.ps  = '0;
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.ps  = st_q.ps + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ps  <= '0;
            st_q.cnt <= CNT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // Counter only ever moves forward by one, wrapping at the top (R1, R9)
    assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(st_q.cnt) |-> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/tcu_edge_sync.sv
module tcu_edge_sync #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_i,
    input  logic             rise_sel_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             stb_o,
    output logic [CNT_W-1:0] stamp_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0]            pin;
        logic [SYNC_STAGES-1:0][CNT_W-1:0] ts;
        logic                              hist;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     lvl_new;

    // Pin level and the counter value at its first sample travel together
    always_comb begin
        st_d      = st_q;
        st_d.pin  = {st_q.pin[LAST-1:0], pin_i};
        st_d.ts   = {st_q.ts[LAST-1:0], cnt_i};
        st_d.hist = st_q.pin[LAST];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_new = st_q.pin[LAST];
    assign stb_o   = rise_sel_i ? (lvl_new & ~st_q.hist) : (~lvl_new & st_q.hist);
    assign stamp_o = st_q.ts[LAST] + 1'b1;

    // A detected edge yields a single-cycle strobe (R3)
    assert_stb_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_o |=> !stb_o);

endmodule

// File: rtl/tcu_capture.sv
module tcu_capture
    import tcu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stb_i,
    input  logic [CNT_W-1:0] stamp_i,
    input  logic             rd_en_i,
    input  logic             rd_addr_i,
    output logic [7:0]       rd_data_o,
    output logic             flag_o
);
    localparam int BYTE_W = CNT_W / 2;

    typedef struct packed {
        logic flag;
        logic lock;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    logic [CNT_W-1:0] cap_d, cap_q;
    logic             rd_hi, rd_lo, take;

    always_comb begin
        rd_hi = rd_en_i && (byte_sel_e'(rd_addr_i) == BYTE_HI);
        rd_lo = rd_en_i && (byte_sel_e'(rd_addr_i) == BYTE_LO);
        // No capture while locked, nor in the cycle the high byte is taken
        take  = stb_i && !st_q.lock && !rd_hi;

        st_d  = st_q;
        cap_d = cap_q;
        if (take) begin
            cap_d = stamp_i;
        end

        if (take) begin
            st_d.flag = 1'b1;
        end else if (rd_lo) begin
            st_d.flag = 1'b0;
        end

        if (rd_lo) begin
            st_d.lock = 1'b0;
        end else if (rd_hi) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Capture contents deliberately survive reset
    always_ff @(posedge clk_i) begin
        cap_q <= cap_d;
    end

    assign rd_data_o = (byte_sel_e'(rd_addr_i) == BYTE_HI) ? cap_q[CNT_W-1:BYTE_W]
                                                           : cap_q[BYTE_W-1:0];
    assign flag_o    = st_q.flag;

    assert_flag_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_i && !st_q.lock && !rd_hi) |=> flag_o);

    assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_lo && !stb_i) |=> !flag_o);

    assert_lock_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lock |=> $stable(cap_q));

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit #(
    parameter int               CNT_W       = 16,
    parameter int               PRESCALE    = 4,
    parameter logic [CNT_W-1:0] CNT_RESET   = 16'hFFFC,
    parameter int               SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cap_pin_i,
    input  logic       edge_rise_i,
    input  logic       rd_en_i,
    input  logic       rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       cap_flag_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] stamp;
    logic             stb;

    tcu_counter #(
        .CNT_W     (CNT_W),
        .PRESCALE  (PRESCALE),
        .CNT_RESET (CNT_RESET)
    ) counter_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cnt_o  (cnt)
    );

    tcu_edge_sync #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (cap_pin_i),
        .rise_sel_i (edge_rise_i),
        .cnt_i      (cnt),
        .stb_o      (stb),
        .stamp_o    (stamp)
    );

    tcu_capture #(
        .CNT_W (CNT_W)
    ) capture_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stb_i     (stb),
        .stamp_i   (stamp),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .flag_o    (cap_flag_o)
    );

endmodule

// File: tb/tmr_capture_unit_tb.sv
module tmr_capture_unit_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       cap_pin_i = 1'b0;
    logic       edge_rise_i = 1'b1;
    logic       rd_en_i = 1'b0;
    logic       rd_addr_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       cap_flag_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  edges    = 0;
    bit  done     = 1'b0;

    always #2 clk_i = ~clk_i;

    tmr_capture_unit dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cap_pin_i   (cap_pin_i),
        .edge_rise_i (edge_rise_i),
        .rd_en_i     (rd_en_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .cap_flag_o  (cap_flag_o)
    );

    // Clock edges since reset release
    always @(posedge clk_i) begin
        if (!rst_ni) edges = 0;
        else         edges = edges + 1;
    end

    function automatic logic [15:0] expect_cap(int n);
        return 16'(32'hFFFC + n / 4 + 1);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_to(int n);
        while (edges < n) @(negedge clk_i);
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0; cap_pin_i = 1'b0; rd_en_i = 1'b0; edge_rise_i = 1'b1;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    task automatic read_byte(logic addr, output logic [7:0] data);
        rd_en_i = 1'b1; rd_addr_i = addr;
        #1 data = rd_data_o;
        @(negedge clk_i);
        rd_en_i = 1'b0;
    endtask

    task automatic read16(output logic [15:0] val);
        logic [7:0] hi, lo;
        read_byte(1'b0, hi);
        read_byte(1'b1, lo);
        val = {hi, lo};
    endtask

    task automatic test_reset_state();
        do_reset();
        check("R6 flag after reset", 16'(cap_flag_o), 16'h0);
    endtask

    task automatic test_rise_capture();
        logic [7:0] b;
        do_reset();
        wait_to(2); cap_pin_i = 1'b1;
        wait_to(4); check("R6 flag not yet", 16'(cap_flag_o), 16'h0);
        wait_to(5); check("R6 flag set", 16'(cap_flag_o), 16'h1);
        read_byte(1'b0, b); check("R4 high byte", 16'(b), 16'(expect_cap(2) >> 8));
        read_byte(1'b1, b); check("R2 low byte", 16'(b), 16'(expect_cap(2) & 16'hFF));
        check("R7 flag cleared", 16'(cap_flag_o), 16'h0);
    endtask

    task automatic test_wrap_and_polarity();
        logic [15:0] v;
        do_reset();
        wait_to(14); cap_pin_i = 1'b1;
        wait_to(17); read16(v);
        check("R9 wrap capture", v, 16'h0000);
        wait_to(40); cap_pin_i = 1'b0;
        wait_to(46); check("R3 falling ignored", 16'(cap_flag_o), 16'h0);
        wait_to(47); edge_rise_i = 1'b0;
        wait_to(50); cap_pin_i = 1'b1;
        wait_to(56); check("R3 rising ignored", 16'(cap_flag_o), 16'h0);
        wait_to(60); cap_pin_i = 1'b0;
        wait_to(63); check("R3 falling flag", 16'(cap_flag_o), 16'h1);
        read16(v);
        check("R1 counter after wrap", v, expect_cap(60));
    endtask

    task automatic test_lock();
        logic [7:0]  b;
        logic [15:0] v;
        do_reset();
        wait_to(8); cap_pin_i = 1'b1;
        wait_to(12); read_byte(1'b0, b);
        check("R8 high byte", 16'(b), 16'hFF);
        wait_to(20); cap_pin_i = 1'b0;
        wait_to(24); cap_pin_i = 1'b1;
        wait_to(30); check("R8 flag held", 16'(cap_flag_o), 16'h1);
        read_byte(1'b1, b);
        check("R8 low byte untouched", 16'(b), 16'(expect_cap(8) & 16'hFF));
        check("R7 flag cleared", 16'(cap_flag_o), 16'h0);
        wait_to(40); cap_pin_i = 1'b0;
        wait_to(44); cap_pin_i = 1'b1;
        wait_to(48); read16(v);
        check("R8 unlocked capture", v, expect_cap(44));
    endtask

    task automatic test_collision();
        logic [7:0]  b;
        logic [15:0] v;
        do_reset();
        wait_to(4); cap_pin_i = 1'b1;
        wait_to(10); cap_pin_i = 1'b0;
        wait_to(20); cap_pin_i = 1'b1;
        wait_to(22); read_byte(1'b1, b);
        check("R7 old low byte", 16'(b), 16'(expect_cap(4) & 16'hFF));
        check("R7 capture beats clear", 16'(cap_flag_o), 16'h1);
        read16(v);
        check("R2 second capture", v, expect_cap(20));
        check("R7 flag cleared", 16'(cap_flag_o), 16'h0);
    endtask

    task automatic test_reset_keeps();
        logic [15:0] v;
        edge_rise_i = 1'b1;
        cap_pin_i = 1'b0;
        repeat (6) @(negedge clk_i);
        do_reset();
        check("R6 flag after reset", 16'(cap_flag_o), 16'h0);
        read16(v);
        check("R5 value kept over reset", v, expect_cap(20));
    endtask

    initial begin
        test_reset_state();
        test_rise_capture();
        test_wrap_and_polarity();
        test_lock();
        test_collision();
        test_reset_keeps();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule